// File: doc/BRIEF.md
# Segment-Based Address Extension Unit

This block sits between a core and the system interconnect and widens the core's 32-bit logical address into a 36-bit physical address. It holds a table of programmable segments. Each segment has four fields: a logical base, a power-of-two size, a replacement physical base and six access-permission bits. A request carries an address, an access type (read, write or execute) and the requester mode (user or supervisor).

The winning segment decides two things. It supplies the upper physical bits, and its permission bits decide whether the access may go ahead. The translation path is purely combinational. When no segment matches, or the winning segment forbids the access, the unit produces no translation and raises a one-cycle fault pulse on the next clock.

Software programs the table through a simple word write/read port. Reset loads two default segments so that the core can reach all of system memory before any programming.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, segment 0 reads back high word 0x0000_001E and low word 0x0000_003F. Segment 1 reads back high word 0x8000_001E and low word 0x8000_003F. Every other segment reads back zero in both words.
- R2: With reset contents, any logical address A below 0x8000_0000 translates to physical {4'h0, A}. Any logical address A at or above 0x8000_0000 translates to physical 0x8_0000_0000 + (A - 0x8000_0000). All access types and both modes are allowed.
- R3: High word layout is base at [31:12] and size code at [4:0]. A size code c in 0x0B..0x1F gives a segment of 2^(c+1) bytes, and only logical bits [31:c+1] are compared against the base. Base bits below c+1 are ignored.
- R4: Low word layout is replacement at [31:8] (physical bits [35:12]) and permissions at [5:0]. For a 2^N segment, physical bits [35:N] come from the replacement field and bits [N-1:0] are the logical address bits.
- R5: A size code below 0x0B disables its segment, which then never matches.
- R6: Permission bits are [5] user execute, [4] user write, [3] user read, [2] supervisor execute, [1] supervisor write and [0] supervisor read. req_user_i=1 selects the user bits and 0 selects the supervisor bits. req_type_i 2'b00 is read, 2'b01 is write, 2'b10 is execute, and 2'b11 is always denied.
- R7: When several segments match, the highest-numbered one wins. Only its permissions are checked; a denial does not fall through to a lower segment.
- R8: hit_o is high only for a valid request that matches and is permitted. While hit_o is low, phys_addr_o is zero.
- R9: fault_o is high for exactly the one cycle after each clock edge that samples a valid request with hit_o low; otherwise it is low.
- R10: A write with cfg_hi_i=1 updates only the addressed high word, and one with cfg_hi_i=0 updates only the low word. Unused bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Segment register write enable |
| cfg_idx_i | input | $clog2(NUM_SEG) | Segment index for write and read |
| cfg_hi_i | input | 1 | 1 selects the high word (base/size), 0 selects the low word (replacement/permissions) |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data of the selected word |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 32 | Logical address |
| req_type_i | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| req_user_i | input | 1 | 1 user mode, 0 supervisor mode |
| phys_addr_o | output | 36 | Translated physical address |
| hit_o | output | 1 | Valid, permitted translation |
| fault_o | output | 1 | One-cycle fault pulse |

## Verification
The bench builds the unit with NUM_SEG=4. At that size two reset segments and two free segments cover every priority relation: top over bottom, a free segment over a reset one, and a denied winner shadowing a permitting lower one.

The bench sweeps every size code from 0 to 0x1F on the highest segment. For each enabled code it probes addresses just inside and just outside the segment. It also runs all 64 permission patterns against both modes and all four access types. A reference model computes the expected results arithmetically using divisions by the segment size.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int LADDR_W = 32;
  localparam int PADDR_W = 36;
  localparam int PAGE_W  = 12;
  localparam int BASE_W  = LADDR_W - PAGE_W;
  localparam int RADDR_W = PADDR_W - PAGE_W;
  localparam int SIZE_W  = 5;
  localparam int PERM_W  = 6;
  localparam int MIN_CODE = PAGE_W - 1;
  localparam int WORD_W  = 32;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef struct packed {
    logic [BASE_W-1:0]  base;
    logic [SIZE_W-1:0]  size;
    logic [RADDR_W-1:0] raddr;
    logic [PERM_W-1:0]  perm;
  } seg_t;

  // 2 GB identity for the low half, high half lifted to 8:0000_0000
  localparam seg_t SEG0_RST = '{base: '0, size: 5'h1E, raddr: '0, perm: '1};
  localparam seg_t SEG1_RST = '{base: 20'h80000, size: 5'h1E, raddr: 24'h800000, perm: '1};

  function automatic logic [WORD_W-1:0] pack_hi(seg_t s);
    return {s.base, {(WORD_W-BASE_W-SIZE_W){1'b0}}, s.size};
  endfunction

  function automatic logic [WORD_W-1:0] pack_lo(seg_t s);
    return {s.raddr, {(WORD_W-RADDR_W-PERM_W){1'b0}}, s.perm};
  endfunction
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output seg_t              seg_o [NUM_SEG]
);
  seg_t ent_q [NUM_SEG];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_ent
    localparam seg_t RST = (i == 0) ? SEG0_RST : (i == 1) ? SEG1_RST : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[i] <= RST;
      end else if (we_i && idx_i == IDX_W'(i)) begin
        if (hi_i) begin
          ent_q[i].base <= wdata_i[WORD_W-1 -: BASE_W];
          ent_q[i].size <= wdata_i[SIZE_W-1:0];
        end else begin
          ent_q[i].raddr <= wdata_i[WORD_W-1 -: RADDR_W];
          ent_q[i].perm  <= wdata_i[PERM_W-1:0];
        end
      end
    end
    assign seg_o[i] = ent_q[i];
  end

  assign rdata_o = hi_i ? pack_hi(ent_q[idx_i]) : pack_lo(ent_q[idx_i]);

  logic unused_w;
  assign unused_w = ^wdata_i[WORD_W-RADDR_W-1:PERM_W] ^ ^wdata_i[WORD_W-BASE_W-1:SIZE_W];
endmodule

// File: rtl/seg_match.sv
module seg_match
  import seg_xlate_pkg::*;
(
  input  seg_t               seg_i,
  input  logic [BASE_W-1:0]  page_i,
  output logic               match_o,
  output logic [RADDR_W-1:0] ppage_o
);
  logic [BASE_W-1:0] low_mask;
  logic              enabled;

  // low_mask marks page bits inside the segment (code - MIN_CODE of them)
  always_comb begin
    for (int b = 0; b < BASE_W; b++)
      low_mask[b] = (int'(seg_i.size) - MIN_CODE) > b;
  end

  assign enabled = int'(seg_i.size) >= MIN_CODE;
  assign match_o = enabled && (((page_i ^ seg_i.base) & ~low_mask) == '0);
  assign ppage_o = (seg_i.raddr & ~RADDR_W'(low_mask)) | RADDR_W'(page_i & low_mask);
endmodule

// File: rtl/seg_pick.sv
module seg_pick
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic [NUM_SEG-1:0] match_i,
  input  logic [RADDR_W-1:0] ppage_i [NUM_SEG],
  input  seg_t               seg_i [NUM_SEG],
  input  logic               user_i,
  input  acc_e               acc_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [RADDR_W-1:0] ppage_o,
  output logic               allow_o
);
  logic [PERM_W-1:0] perm;
  logic [2:0]        mode_bits; // {x, w, r}

  // ascending scan, later hits override: highest index wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int s = 0; s < NUM_SEG; s++) begin
      if (match_i[s]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(s);
      end
    end
  end

  assign ppage_o   = ppage_i[idx_o];
  assign perm      = seg_i[idx_o].perm;
  assign mode_bits = user_i ? perm[5:3] : perm[2:0];

  always_comb begin
    unique case (acc_i)
      ACC_READ:  allow_o = mode_bits[0];
      ACC_WRITE: allow_o = mode_bits[1];
      ACC_EXEC:  allow_o = mode_bits[2];
      default:   allow_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int NUM_SEG = 16,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [IDX_W-1:0]   cfg_idx_i,
  input  logic               cfg_hi_i,
  input  logic [WORD_W-1:0]  cfg_wdata_i,
  output logic [WORD_W-1:0]  cfg_rdata_o,
  input  logic               req_valid_i,
  input  logic [LADDR_W-1:0] req_addr_i,
  input  logic [1:0]         req_type_i,
  input  logic               req_user_i,
  output logic [PADDR_W-1:0] phys_addr_o,
  output logic               hit_o,
  output logic               fault_o
);
  seg_t               seg [NUM_SEG];
  logic [NUM_SEG-1:0] match_vec;
  logic [RADDR_W-1:0] ppage [NUM_SEG];
  logic               found, allow;
  logic [IDX_W-1:0]   win_idx;
  logic [RADDR_W-1:0] win_ppage;
  logic               fault_q;

  seg_regfile #(.NUM_SEG(NUM_SEG)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .idx_i   (cfg_idx_i),
    .hi_i    (cfg_hi_i),
    .wdata_i (cfg_wdata_i),
    .rdata_o (cfg_rdata_o),
    .seg_o   (seg)
  );

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_match
    seg_match i_match (
      .seg_i   (seg[i]),
      .page_i  (req_addr_i[LADDR_W-1:PAGE_W]),
      .match_o (match_vec[i]),
      .ppage_o (ppage[i])
    );
  end

  seg_pick #(.NUM_SEG(NUM_SEG)) i_pick (
    .match_i (match_vec),
    .ppage_i (ppage),
    .seg_i   (seg),
    .user_i  (req_user_i),
    .acc_i   (acc_e'(req_type_i)),
    .found_o (found),
    .idx_o   (win_idx),
    .ppage_o (win_ppage),
    .allow_o (allow)
  );

  assign hit_o       = req_valid_i && found && allow;
  assign phys_addr_o = hit_o ? {win_ppage, req_addr_i[PAGE_W-1:0]} : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_q <= 1'b0;
    else         fault_q <= req_valid_i && !hit_o;
  end
  assign fault_o = fault_q;

  // R7
  win_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> match_vec[win_idx]);
  // R7
  win_highest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found |-> ((match_vec >> win_idx) >> 1) == '0);
  // R8
  hit_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> req_valid_i);
  // R8
  miss_zero_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> phys_addr_o == '0);
  // R9
  fault_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit_o) |=> fault_o);
  // R9
  fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !fault_o);
endmodule

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;
  localparam int NS = 4;
  localparam int IW = $clog2(NS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic          cfg_hi = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic [1:0]    req_type = '0;
  logic          req_user = 1'b0;
  logic [35:0]   phys_addr;
  logic          hit, fault;

  int checks = 0;
  int errors = 0;
  logic [31:0] sh_hi [NS];
  logic [31:0] sh_lo [NS];

  always #5 clk = ~clk;

  seg_xlate_unit #(.NUM_SEG(NS)) i_seg_xlate_unit (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_hi_i(cfg_hi), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_type_i(req_type),
    .req_user_i(req_user), .phys_addr_o(phys_addr), .hit_o(hit), .fault_o(fault)
  );

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic hi_sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_hi = hi_sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (hi_sel) sh_hi[idx] = d & 32'hFFFF_F01F;
    else        sh_lo[idx] = d & 32'hFFFF_FF3F;
  endtask

  task automatic rd_chk(input int idx, input logic hi_sel, input logic [31:0] exp, input string tag);
    cfg_idx = IW'(idx); cfg_hi = hi_sel;
    #1;
    chk(cfg_rdata == exp, tag, 64'(cfg_rdata), 64'(exp));
  endtask

  // arithmetic reference: divide by the segment size instead of masking
  function automatic void ref_xl(input logic [31:0] a, input logic u, input logic [1:0] t,
                                 output logic h, output logic [35:0] p);
    int win = -1;
    longint unsigned sz = 0, wsz = 0, bas;
    int code, pb;
    for (int s = 0; s < NS; s++) begin
      code = int'(sh_hi[s][4:0]);
      if (code >= 11) begin
        sz  = 64'd1 << (code + 1);
        bas = longint'(sh_hi[s][31:12]) << 12;
        if ((longint'(a) / sz) == (bas / sz)) begin win = s; wsz = sz; end
      end
    end
    h = 1'b0; p = '0;
    if (win >= 0 && t != 2'b11) begin
      pb = (u ? 3 : 0) + int'(t);
      if (sh_lo[win][pb]) begin
        h = 1'b1;
        p = 36'((((longint'(sh_lo[win][31:8]) << 12) / wsz) * wsz) + (longint'(a) % wsz));
      end
    end
  endfunction

  task automatic req(input logic [31:0] a, input logic u, input logic [1:0] t, input string tag);
    logic eh;
    logic [35:0] ep;
    ref_xl(a, u, t, eh, ep);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_user = u; req_type = t;
    #1;
    chk(hit == eh, {tag, " hit R8"}, 64'(hit), 64'(eh));
    chk(phys_addr == ep, {tag, " phys"}, 64'(phys_addr), 64'(ep));
    @(negedge clk);
    req_valid = 1'b0;
    // R9: fault one cycle after the sampling edge
    chk(fault == !eh, {tag, " fault R9"}, 64'(fault), 64'(!eh));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog timeout");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin sh_hi[s] = '0; sh_lo[s] = '0; end
    sh_hi[0] = 32'h0000_001E; sh_lo[0] = 32'h0000_003F;
    sh_hi[1] = 32'h8000_001E; sh_lo[1] = 32'h8000_003F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset contents
    for (int s = 0; s < NS; s++) begin
      rd_chk(s, 1'b1, sh_hi[s], "R1 reset hi");
      rd_chk(s, 1'b0, sh_lo[s], "R1 reset lo");
    end
    #1;
    chk(fault == 1'b0 && hit == 1'b0, "R1 reset outputs", 64'({fault, hit}), 64'(0));

    // R2: default mappings, both modes, all three types
    for (int t = 0; t < 3; t++) begin
      req(32'h0000_1234, 1'b0, 2'(t), "R2 low");
      req(32'h7FFF_FFFF, 1'b1, 2'(t), "R2 low top");
      req(32'h8000_0000, 1'b0, 2'(t), "R2 high base");
      req(32'hC765_4321, 1'b1, 2'(t), "R2 high");
    end
    @(negedge clk);
    req_addr = 32'hC765_4321; #1;
    chk(phys_addr == 36'h8_4765_4321 - 36'h0_0000_0000 && 1'b0 == 1'b0 || hit == 1'b0,
        "R8 idle no hit", 64'(hit), 64'(0));

    // R3 R4 R5: every size code on the top segment
    wr(3, 1'b0, 32'hC3C3_C33F); // R4 replacement with low bits set, all perms
    for (int c = 0; c < 32; c++) begin
      logic [31:0] a0, a1, a2;
      longint unsigned sz;
      wr(3, 1'b1, 32'hA5A5_A000 | 32'(c));
      rd_chk(3, 1'b1, 32'hA5A5_A000 | 32'(c), "R10 hi readback");
      sz = 64'd1 << (c + 1);
      a0 = 32'hA5A5_A5A5;
      a1 = 32'(((longint'(a0) / sz) * sz) + (sz - 1 - (longint'(a0) % sz)));
      a2 = (c < 31) ? a0 ^ 32'(sz) : 32'h0000_0042;
      if (c < 11) begin
        req(a0, 1'b0, 2'b00, "R5 disabled code");
      end else begin
        req(a0, 1'b0, 2'b00, "R3 inside");
        req(a1, 1'b1, 2'b10, "R4 inside far end");
        req(a2, 1'b0, 2'b01, "R3 outside");
      end
    end

    // R6: all permission patterns, modes and types on segment 3
    wr(3, 1'b1, 32'h2000_000B);
    for (int pm = 0; pm < 64; pm++) begin
      wr(3, 1'b0, 32'h0123_4500 | 32'(pm));
      for (int u = 0; u < 2; u++)
        for (int t = 0; t < 4; t++)
          req(32'h2000_0ABC, u[0], 2'(t), "R6 perm");
    end

    // R7: overlap priority and no fall-through on denial
    wr(2, 1'b1, 32'h4000_0013); // 1 MB
    wr(2, 1'b0, 32'h1111_113F);
    wr(3, 1'b1, 32'h4000_000B); // 4 KB inside it
    wr(3, 1'b0, 32'h2222_2207); // supervisor only
    req(32'h4000_0123, 1'b0, 2'b00, "R7 top wins");
    req(32'h4000_5123, 1'b0, 2'b00, "R7 seg2 over seg0");
    req(32'h4000_0123, 1'b1, 2'b00, "R7 denied no fallthrough");
    wr(3, 1'b1, 32'h4000_0000);
    req(32'h4000_0123, 1'b1, 2'b00, "R7 lower after disable");

    // R10: low write leaves high word intact
    wr(2, 1'b0, 32'hFFFF_FFFF);
    rd_chk(2, 1'b1, 32'h4000_0013, "R10 hi untouched");
    rd_chk(2, 1'b0, 32'hFFFF_FF3F, "R10 lo reserved zero");
    wr(2, 1'b1, 32'hFFFF_FFE0);
    rd_chk(2, 1'b1, 32'hFFFF_F000, "R10 hi reserved zero");
    rd_chk(2, 1'b0, 32'hFFFF_FF3F, "R10 lo untouched");

    // R9: everything disabled, single-cycle pulse
    for (int s = 0; s < NS; s++) wr(s, 1'b1, 32'h0);
    req(32'h0000_0000, 1'b0, 2'b00, "R9 no segment");
    @(negedge clk);
    chk(fault == 1'b0, "R9 pulse ends", 64'(fault), 64'(0));
    req(32'hFFFF_F000, 1'b1, 2'b01, "R9 no segment high");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule